// File: doc/BRIEF.md
# Eight-bit compare-match timer channel

This block is one timer channel built around an 8-bit up-counter. The counter moves forward by one on every clock where the count-enable input is high, and two compare registers are matched against it. A byte-wide register port with separate read and write strobes reaches four registers: the counter, compare value A, compare value B, and a combined control/status register. Each time the counter advances onto a matching value, or wraps from 0xFF to 0x00, the block raises a one-cycle internal event. That event sets a sticky status flag.

Software clears a flag in two steps. It first reads the status register while the flag is 1, which arms the flag. It then writes 0 to that bit. Event A can also raise a single-clock start request toward a converter when the trigger enable bit is set. Events A and B each act on one shared output pin, each through its own 2-bit action field. The possible actions are hold, force low, force high and toggle.

Top module: `cmt8_timer`

## Requirements
- R1: The counter (address 0) rises by one, wrapping 0xFF to 0x00, at each clock edge where `cnt_en` is high. A bus write to address 0 loads the counter and takes precedence over counting in the same cycle.
- R2: Flag A (status bit 6) becomes 1 at the clock edge that ends the cycle in which the counter has just advanced onto the value of compare register A (address 1).
- R3: Flag B (status bit 7) becomes 1 in the same way for compare register B (address 2).
- R4: The overflow flag (status bit 5) becomes 1 after the counter advances from 0xFF to 0x00. Loading 0x00 over the bus does not set it.
- R5: Reading the status register (address 3) arms each flag that reads as 1. A later status write with 0 in an armed flag's bit clears that flag. A 0 written to an unarmed flag, or a 1 written to any flag, leaves the flag unchanged.
- R6: When a hardware event and a software clear hit the same flag in the same cycle, the flag stays 1.
- R7: `adc_start` is high for exactly the one cycle of an A event when status bit 4 is 1. It stays low when bit 4 is 0.
- R8: Status bits 3:2 select the pin action for a B event, applied at the next edge: 00 hold, 01 drive 0, 10 drive 1, 11 invert.
- R9: Status bits 1:0 select the pin action for an A event, using the same encoding. When A and B events coincide, only the B field is used, including the hold code 00.
- R10: After reset the counter, both compare registers and all status and control bits read 0, `tmr_out` is 0, and `adc_start` is 0.
- R11: `tmr_out` does not change in any cycle without an A or B event, including cycles that contain register writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Prescaled count enable |
| bus_addr | input | 2 | Register select: 0 counter, 1 compare A, 2 compare B, 3 control/status |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a status read arms set flags |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| adc_start | output | 1 | One-cycle converter start request |
| tmr_out | output | 1 | Timer output pin |

## Verification
The assertions assume that a compare register is not rewritten during the cycle in which its event is being evaluated. They also assume that read and write strobes never hit the status register in the same cycle. The stimulus keeps to both assumptions by issuing one bus operation per cycle. It also loads the counter to one value below the target and then gives a single count-enable pulse, so every event starts from a known, quiet state. The sweeps use widely spaced compare values, so one channel's event never lands on another channel's target by accident.

// File: rtl/cmt8_pkg.sv
package cmt8_pkg;

  typedef enum logic [1:0] {
    SEL_CNT  = 2'd0,
    SEL_CMPA = 2'd1,
    SEL_CMPB = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } pin_act_e;

  localparam int NUM_FLAGS   = 3;
  localparam int NUM_CMP     = 2;
  localparam int CTRL_BITS   = 5;
  localparam int TRIG_EN_POS = 4;

  // B event wins over A event; otherwise the pin is left alone.
  function automatic pin_act_e pick_act(input logic hit_a, input logic hit_b,
                                        input logic [1:0] sel_a,
                                        input logic [1:0] sel_b);
    pin_act_e act;
    if (hit_b)      act = pin_act_e'(sel_b);
    else if (hit_a) act = pin_act_e'(sel_a);
    else            act = ACT_KEEP;
    return act;
  endfunction

  function automatic logic pin_next(input pin_act_e act, input logic cur);
    logic nxt;
    case (act)
      ACT_LOW:  nxt = 1'b0;
      ACT_HIGH: nxt = 1'b1;
      ACT_FLIP: nxt = ~cur;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

endpackage

// File: rtl/cmt8_counter.sv
module cmt8_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         adv_q,
  output logic         wrap_evt
);
  localparam logic [W-1:0] ZERO = '0;
  localparam logic [W-1:0] ONE  = W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= ZERO;
      adv_q <= 1'b0;
    end else begin
      adv_q <= cnt_en & ~load;
      if (load)        cnt <= load_val;
      else if (cnt_en) cnt <= cnt + ONE;
    end
  end

  // Counter just advanced and now holds zero: it came from all-ones.
  assign wrap_evt = adv_q && (cnt == ZERO);
endmodule

// File: rtl/cmt8_match.sv
module cmt8_match #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wval,
  input  logic [W-1:0] cnt,
  input  logic         adv_q,
  output logic [W-1:0] cmp,
  output logic         hit
);
  always_ff @(posedge clk) begin
    if (!rst_n)  cmp <= '0;
    else if (wr) cmp <= wval;
  end

  assign hit = adv_q && (cnt == cmp);
endmodule

// File: rtl/cmt8_flags.sv
module cmt8_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic         rd_stat,
  input  logic         wr_stat,
  input  logic [N-1:0] wbits,
  output logic [N-1:0] flags,
  output logic [N-1:0] armed
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic clr_req;
    assign clr_req = wr_stat && !wbits[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flags[i] <= 1'b0;
        armed[i] <= 1'b0;
      end else begin
        if (set_evt[i])                 flags[i] <= 1'b1;
        else if (clr_req && armed[i])   flags[i] <= 1'b0;

        if (clr_req)                    armed[i] <= 1'b0;
        else if (rd_stat && flags[i])   armed[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/cmt8_pin.sv
module cmt8_pin
  import cmt8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hit_a,
  input  logic       hit_b,
  input  logic [1:0] sel_a,
  input  logic [1:0] sel_b,
  output logic       pin_q
);
  pin_act_e act;
  assign act = pick_act(hit_a, hit_b, sel_a, sel_b);

  always_ff @(posedge clk) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_next(act, pin_q);
  end
endmodule

// File: rtl/cmt8_timer.sv
module cmt8_timer
  import cmt8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [1:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_rd,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  output logic         adc_start,
  output logic         tmr_out
);
  localparam int STAT_W = NUM_FLAGS + CTRL_BITS;

  reg_sel_e sel;
  assign sel = reg_sel_e'(bus_addr);

  logic wr_cnt, wr_ctrl, rd_ctrl;
  logic [NUM_CMP-1:0] wr_cmp;
  assign wr_cnt    = bus_wr && (sel == SEL_CNT);
  assign wr_cmp[0] = bus_wr && (sel == SEL_CMPA);
  assign wr_cmp[1] = bus_wr && (sel == SEL_CMPB);
  assign wr_ctrl   = bus_wr && (sel == SEL_CTRL);
  assign rd_ctrl   = bus_rd && (sel == SEL_CTRL);

  // Counter
  logic [W-1:0] cnt_q;
  logic         adv_q, wrap_evt;

  cmt8_counter #(.W(W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .load     (wr_cnt),
    .load_val (bus_wdata),
    .cnt      (cnt_q),
    .adv_q    (adv_q),
    .wrap_evt (wrap_evt)
  );

  // Compare channels: index 0 is A, index 1 is B
  logic [W-1:0]       cmp_val [NUM_CMP];
  logic [NUM_CMP-1:0] hit;

  for (genvar c = 0; c < NUM_CMP; c++) begin : g_cmp
    cmt8_match #(.W(W)) u_match (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_cmp[c]),
      .wval  (bus_wdata),
      .cnt   (cnt_q),
      .adv_q (adv_q),
      .cmp   (cmp_val[c]),
      .hit   (hit[c])
    );
  end

  logic hit_a, hit_b;
  assign hit_a = hit[0];
  assign hit_b = hit[1];

  // Control field
  logic [CTRL_BITS-1:0] ctrl_q;
  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata[CTRL_BITS-1:0];
  end

  logic [1:0] osel_a, osel_b;
  logic       trig_en;
  assign osel_a  = ctrl_q[1:0];
  assign osel_b  = ctrl_q[3:2];
  assign trig_en = ctrl_q[TRIG_EN_POS];

  // Flags, MSB first: {B, A, overflow}
  logic [NUM_FLAGS-1:0] set_evt, flags_q, armed_q;
  assign set_evt = {hit_b, hit_a, wrap_evt};

  cmt8_flags #(.N(NUM_FLAGS)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_evt),
    .rd_stat (rd_ctrl),
    .wr_stat (wr_ctrl),
    .wbits   (bus_wdata[STAT_W-1:CTRL_BITS]),
    .flags   (flags_q),
    .armed   (armed_q)
  );

  // Output pin
  cmt8_pin u_pin (
    .clk   (clk),
    .rst_n (rst_n),
    .hit_a (hit_a),
    .hit_b (hit_b),
    .sel_a (osel_a),
    .sel_b (osel_b),
    .pin_q (tmr_out)
  );

  assign adc_start = hit_a & trig_en;

  // Read mux
  logic [STAT_W-1:0] stat_word;
  assign stat_word = {flags_q, ctrl_q};

  always_comb begin
    case (sel)
      SEL_CNT:  bus_rdata = cnt_q;
      SEL_CMPA: bus_rdata = cmp_val[0];
      SEL_CMPB: bus_rdata = cmp_val[1];
      default:  bus_rdata = W'(stat_word);
    endcase
  end
endmodule

// File: rtl/cmt8_timer_chk.sv
module cmt8_timer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cnt_en,
  input logic         wr_cnt,
  input logic [W-1:0] cnt_q,
  input logic         hit_a,
  input logic         hit_b,
  input logic         wrap_evt,
  input logic [2:0]   flags_q,
  input logic [2:0]   armed_q,
  input logic [4:0]   ctrl_q,
  input logic         adc_start,
  input logic         tmr_out
);
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !wr_cnt) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

  assert_flag_a_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> flags_q[1]);

  assert_flag_b_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit_b |=> flags_q[2]);

  assert_flag_ovf_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> flags_q[0]);

  assert_unarmed_flag_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q & ~armed_q)) == $past(flags_q & ~armed_q)));

  assert_trig_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start |=> (!adc_start && flags_q[1]));

  assert_pin_b_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && ctrl_q[3:2] == 2'b01) |=> !tmr_out);

  assert_pin_b_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_b && ctrl_q[3:2] == 2'b10) |=> tmr_out);

  assert_pin_a_flip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_a && !hit_b && ctrl_q[1:0] == 2'b11) |=> (tmr_out != $past(tmr_out)));

  assert_pin_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit_a && !hit_b) |=> $stable(tmr_out));
endmodule

bind cmt8_timer cmt8_timer_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .wr_cnt    (wr_cnt),
  .cnt_q     (cnt_q),
  .hit_a     (hit_a),
  .hit_b     (hit_b),
  .wrap_evt  (wrap_evt),
  .flags_q   (flags_q),
  .armed_q   (armed_q),
  .ctrl_q    (ctrl_q),
  .adc_start (adc_start),
  .tmr_out   (tmr_out)
);

// File: tb/cmt8_timer_tb.sv
`timescale 1ns/1ps
module cmt8_timer_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cnt_en = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       adc_start, tmr_out;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  cmt8_timer #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .adc_start(adc_start), .tmr_out(tmr_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge.
  task automatic wr(input logic [1:0] a, input logic [7:0] d, input logic en = 1'b0);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; cnt_en = en;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic step();
    cnt_en = 1'b1;
    @(posedge clk); @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic pin_model(input int mode, input logic cur);
    if (mode == 3) return !cur;
    if (mode == 0) return cur;
    return (mode == 2);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    logic [7:0] v;
    logic       p;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R10 reset state
    chk("R10 pin", {7'b0, tmr_out}, 8'h00);
    chk("R10 start", {7'b0, adc_start}, 8'h00);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      chk("R10 register", d, 8'h00);
    end

    // R1 counting
    wr(2'd1, 8'hA0);
    wr(2'd2, 8'hB0);
    v = 8'h10;
    wr(2'd0, v);
    for (int n = 1; n <= 7; n += 3) begin
      repeat (n) step();
      v = v + 8'(n);
      rd(2'd0, d);
      chk("R1 count", d, v);
    end
    wr(2'd0, 8'hFE);
    step(); step();
    rd(2'd0, d);
    chk("R1 wrap", d, 8'h00);
    // R4 overflow flag
    rd(2'd3, d);
    chk("R4 overflow set", d, 8'h20);
    wr(2'd3, 8'h00);
    rd(2'd3, d);
    chk("R5 clear after read", d, 8'h00);
    // R1 load beats count
    wr(2'd0, 8'h40, 1'b1);
    rd(2'd0, d);
    chk("R1 load priority", d, 8'h40);
    // R4 loading zero is not a wrap
    wr(2'd0, 8'hFF);
    wr(2'd0, 8'h00);
    rd(2'd3, d);
    chk("R4 load zero", d, 8'h00);

    // R2 / R7 sweep of compare A with trigger enable alternating
    for (int i = 0; i < 16; i++) begin
      logic       te;
      logic [7:0] val;
      logic [7:0] cw;
      te  = i[0];
      val = 8'(i * 16 + 5);
      cw  = {3'b000, te, 4'b0000};
      wr(2'd3, cw);
      wr(2'd1, val);
      wr(2'd0, val - 8'd1);
      step();
      chk("R7 start in event cycle", {7'b0, adc_start}, {7'b0, te});
      idle();
      chk("R7 start one cycle", {7'b0, adc_start}, 8'h00);
      rd(2'd3, d);
      chk("R2 flag A set", d, cw | 8'h40);
      wr(2'd3, cw);
      rd(2'd3, d);
      chk("R5 flag A cleared", d, cw);
    end

    // R3 / R5 flag B handshake
    wr(2'd3, 8'h00);
    wr(2'd2, 8'h33);
    wr(2'd0, 8'h32);
    step(); idle();
    wr(2'd3, 8'h00);
    rd(2'd3, d);
    chk("R3 flag B set and R5 unarmed write ignored", d, 8'h80);
    wr(2'd3, 8'h80);
    rd(2'd3, d);
    chk("R5 write one ignored", d, 8'h80);
    wr(2'd3, 8'h00);
    rd(2'd3, d);
    chk("R5 armed clear", d, 8'h00);

    // R6 set beats clear
    wr(2'd0, 8'h32);
    step(); idle();
    rd(2'd3, d);
    chk("R6 flag B before", d, 8'h80);
    wr(2'd0, 8'h32);
    step();
    wr(2'd3, 8'h00);
    rd(2'd3, d);
    chk("R6 set wins", d, 8'h80);
    wr(2'd3, 8'h00);
    rd(2'd3, d);
    chk("R6 cleared afterwards", d, 8'h00);

    // R8 / R11 pin actions by compare B
    p = 1'b0;
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 2; k++) begin
        wr(2'd3, {4'b0000, m[1:0], 2'b00});
        wr(2'd0, 8'h32);
        chk("R11 pin quiet during writes", {7'b0, tmr_out}, {7'b0, p});
        step();
        idle();
        p = pin_model(m, p);
        chk("R8 pin action", {7'b0, tmr_out}, {7'b0, p});
      end
    end

    // R9 pin actions by compare A
    wr(2'd1, 8'h60);
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 2; k++) begin
        wr(2'd3, {6'b000000, m[1:0]});
        wr(2'd0, 8'h5F);
        step();
        idle();
        p = pin_model(m, p);
        chk("R9 pin action A", {7'b0, tmr_out}, {7'b0, p});
      end
    end

    // R9 coincident events: B field rules
    wr(2'd1, 8'h70);
    wr(2'd2, 8'h70);
    for (int j = 0; j < 3; j++) begin
      int mb, ma;
      mb = (j == 0) ? 1 : (j == 1) ? 2 : 0;
      ma = (j == 0) ? 2 : (j == 1) ? 1 : 3;
      wr(2'd3, {4'b0000, mb[1:0], ma[1:0]});
      wr(2'd0, 8'h6F);
      step();
      idle();
      p = pin_model(mb, p);
      chk("R9 B wins on coincidence", {7'b0, tmr_out}, {7'b0, p});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule